// File: doc/BRIEF.md
# Johnson Decade Counter with Decoded Outputs

This block counts clock edges modulo ten using a five-stage twisted-ring (Johnson) register. Each count is turned into one of ten one-hot outputs by a gate that looks at just two ring bits. Only one ring bit changes per count, so the decode cannot glitch. A carry output toggles with a 50% duty cycle and completes one period every ten counted edges, which lets it drive the enable or clock of a following counter stage in a chain.

A hold input freezes the count without stopping the clock. A synchronous active-high reset returns the ring to count zero. A preload port writes any raw five-bit pattern into the ring. This port exists so that the self-correcting feedback can be exercised. One middle stage of the ring takes a guarded feedback instead of a plain shift. Any of the 22 patterns that lie outside the legal ten-state sequence therefore falls back into that sequence within a bounded number of counts. The decoded outputs and the carry are registered and always reflect the current ring contents.

Top module: `johnson_decade`

## Requirements
- R1: With `rst`, `load_en` and `hold_i` low, each rising clock edge advances the count by one, in the order 0,1,...,9, and then wraps back to 0.
- R2: With `hold_i` high, and `rst` and `load_en` low, a clock edge leaves `count_o` and `carry_o` unchanged.
- R3: A rising edge with `rst` high sets the count to zero: `count_o` = 10'b0000000001 and `carry_o` = 1. This happens regardless of `hold_i`, `load_en` or `load_ring`.
- R4: For every legal count k, `count_o` has exactly bit k set. While the counter runs freely, each output stays high for exactly one clock period.
- R5: `carry_o` is high for counts 0 to 4 and low for counts 5 to 9, giving a period of ten counted edges and a 50% duty cycle.
- R6: A rising edge with `load_en` high and `rst` low copies `load_ring` into the ring, even when `hold_i` is high. Bit i of `load_ring` is stage i. The legal pattern for count k is: ones in bits 0..k-1 for k = 0..4, and all ones with bits 0..k-6 cleared for k = 5..9. For example, 5'b00111 is count 3 and 5'b11100 is count 7.
- R7: From any of the 22 illegal ring patterns, the counter reaches a legal pattern after at most 10 uninhibited clock edges. From that point it follows the R1 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count moves on the rising edge |
| rst | input | 1 | Synchronous active-high reset to count zero |
| hold_i | input | 1 | High freezes the count |
| load_en | input | 1 | High writes `load_ring` into the ring at the next edge |
| load_ring | input | 5 | Raw ring pattern for preload, bit i = stage i |
| count_o | output | 10 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | Cascade output, high for counts 0 to 4 |

## Verification
The hardest condition to reach is an illegal ring pattern. Reset and counting can never produce one, so the anti-lock path would go unexercised from the functional inputs alone. The bench uses the preload port to write each of the 22 illegal patterns in turn. It then runs ten free clocks and reads the count that the one-hot output has settled on. From there it checks ten further counts against its reference model, which shows that recovery lands on the legal sequence and stays there.

// File: rtl/jd_pkg.sv
package jd_pkg;
  // Which update the ring takes at the next edge, highest priority first.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_KEEP  = 2'd2,
    OP_SHIFT = 2'd3
  } jd_op_e;

  function automatic jd_op_e pick_op(input logic rst, input logic load_en, input logic hold);
    if (rst)          return OP_CLEAR;
    else if (load_en) return OP_LOAD;
    else if (hold)    return OP_KEEP;
    else              return OP_SHIFT;
  endfunction
endpackage

// File: rtl/jd_ring_next.sv
module jd_ring_next #(
  parameter int STAGES = 5,
  parameter int GUARD  = 2
) (
  input  logic              rst,
  input  logic              load_en,
  input  logic              hold,
  input  logic [STAGES-1:0] load_ring,
  input  logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_d
);
  import jd_pkg::*;

  logic [STAGES-1:0] shifted;
  jd_op_e            op;

  // Twisted ring: inverted top stage feeds stage 0. The guard stage passes
  // its lower neighbour only when that one is backed by a one on either
  // side, so an isolated one is squeezed out and illegal cycles collapse.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign shifted[i] = ~ring_q[STAGES-1];
      end else if (i == GUARD) begin : g_guard
        assign shifted[i] = ring_q[i-1] & (ring_q[i-2] | ring_q[i]);
      end else begin : g_plain
        assign shifted[i] = ring_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    op = pick_op(rst, load_en, hold);
    unique case (op)
      OP_CLEAR: ring_d = '0;
      OP_LOAD:  ring_d = load_ring;
      OP_KEEP:  ring_d = ring_q;
      default:  ring_d = shifted;
    endcase
  end
endmodule

// File: rtl/jd_decode.sv
module jd_decode #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [OUTS-1:0]   onehot,
  output logic              carry
);
  // Each count is identified by the single boundary between ones and zeros,
  // so two ring bits suffice for every output.
  generate
    for (genvar k = 0; k < OUTS; k++) begin : g_dec
      if (k == 0) begin : g_zero
        assign onehot[k] = ~ring[STAGES-1] & ~ring[0];
      end else if (k < STAGES) begin : g_fill
        assign onehot[k] = ring[k-1] & ~ring[k];
      end else if (k == STAGES) begin : g_full
        assign onehot[k] = ring[STAGES-1] & ring[0];
      end else begin : g_drain
        assign onehot[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
      end
    end
  endgenerate

  assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade #(
  parameter int STAGES = 5,
  parameter int GUARD  = 2,
  localparam int OUTS  = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_ring,
  output logic [OUTS-1:0]   count_o,
  output logic              carry_o
);
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [OUTS-1:0]   dec_d;
  logic              carry_d;

  jd_ring_next #(.STAGES(STAGES), .GUARD(GUARD)) u_next (
    .rst       (rst),
    .load_en   (load_en),
    .hold      (hold_i),
    .load_ring (load_ring),
    .ring_q    (ring_q),
    .ring_d    (ring_d)
  );

  // Decode the next ring value so the registered outputs line up with ring_q.
  jd_decode #(.STAGES(STAGES)) u_dec (
    .ring   (ring_d),
    .onehot (dec_d),
    .carry  (carry_d)
  );

  always_ff @(posedge clk) begin
    ring_q  <= ring_d;
    count_o <= dec_d;
    carry_o <= carry_d;
  end
endmodule

// File: rtl/jd_checker.sv
module jd_checker #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES,
  localparam int CW    = $clog2(OUTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_i,
  input logic              load_en,
  input logic [OUTS-1:0]   count_o,
  input logic              carry_o
);
  // Counts shifts since the last preload. The ring is known to be legal
  // after reset or after OUTS shifts.
  logic [CW-1:0] since_q = '0;
  logic          rst_seen_q = 1'b0;
  logic          legal;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst)
      since_q <= CW'(OUTS);
    else if (load_en)
      since_q <= '0;
    else if (!hold_i && since_q != CW'(OUTS))
      since_q <= since_q + 1'b1;
  end

  assign legal = (since_q == CW'(OUTS));

  always_ff @(posedge clk) begin
    if (rst_seen_q)
      AST_RESET_ZERO: assert (count_o == OUTS'(1) && carry_o); // R3
  end

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !load_en) |=> ($stable(count_o) && $stable(carry_o))); // R2

  AST_STEP_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (legal && !hold_i && !load_en) |=> (count_o == {$past(count_o[OUTS-2:0]), $past(count_o[OUTS-1])})); // R1

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    legal |-> ($countones(count_o) == 1)); // R4

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    legal |-> (carry_o == (|count_o[STAGES-1:0]))); // R5
endmodule

bind johnson_decade jd_checker #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hold_i  (hold_i),
  .load_en (load_en),
  .count_o (count_o),
  .carry_o (carry_o)
);

// File: tb/sim_johnson_decade.sv
`timescale 1ns/1ps
module sim_johnson_decade;
  localparam int S = 5;
  localparam int N = 2 * S;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hold_i = 1'b0;
  logic         load_en = 1'b0;
  logic [S-1:0] load_ring = '0;
  logic [N-1:0] count_o;
  logic         carry_o;

  int total = 0;
  int bad = 0;
  int m_cnt = 0;
  bit m_known = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  johnson_decade #(.STAGES(S)) u0 (
    .clk(clk), .rst(rst), .hold_i(hold_i), .load_en(load_en),
    .load_ring(load_ring), .count_o(count_o), .carry_o(carry_o)
  );

  function automatic logic [S-1:0] legal_pat(input int k);
    if (k < S) return S'((1 << k) - 1);
    return S'(((1 << S) - 1) ^ ((1 << (k - S)) - 1));
  endfunction

  function automatic int pat_index(input logic [S-1:0] p);
    for (int k = 0; k < N; k++) if (legal_pat(k) == p) return k;
    return -1;
  endfunction

  task automatic compare(input string req);
    logic [N-1:0] exp_c;
    logic         exp_y;
    if (!m_known) return;
    exp_c = N'(1) << m_cnt;
    exp_y = (m_cnt < S);
    total++;
    if (count_o !== exp_c || carry_o !== exp_y) begin
      bad++;
      $display("FAIL %s: count=%b carry=%b expected count=%b carry=%b", req, count_o, carry_o, exp_c, exp_y);
    end
  endtask

  // Entered at a falling edge: drive, clock, update model, sample at next fall.
  task automatic cyc(input bit r, input bit l, input logic [S-1:0] v, input bit h, input string req);
    int idx;
    rst = r; load_en = l; load_ring = v; hold_i = h;
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_known = 1'b1;
    end else if (l) begin
      idx = pat_index(v);
      m_known = (idx >= 0);
      if (idx >= 0) m_cnt = idx;
    end else if (!h && m_known) begin
      m_cnt = (m_cnt + 1) % N;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, '0, 0, "R3");
    cyc(1, 0, '0, 0, "R3");
    // free run through several wraps
    for (int i = 0; i < 25; i++) cyc(0, 0, '0, 0, "R1 R4 R5");
    // hold in mid count
    for (int i = 0; i < 5; i++) cyc(0, 0, '0, 1, "R2");
    for (int i = 0; i < 7; i++) cyc(0, 0, '0, 0, "R1");
    // alternate hold and step
    for (int i = 0; i < 12; i++) cyc(0, 0, '0, i[0], "R2 R1");
    // reset overrides load and hold
    cyc(1, 1, 5'b10101, 1, "R3");
    cyc(0, 0, '0, 0, "R1");
    // legal preloads, one with hold high
    cyc(0, 1, 5'b00111, 0, "R6");
    cyc(0, 0, '0, 0, "R6");
    cyc(0, 1, 5'b11100, 1, "R6");
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, 0, "R6 R5");
    // every illegal pattern recovers
    for (int p = 0; p < (1 << S); p++) begin
      int idx;
      if (pat_index(S'(p)) >= 0) continue;
      cyc(0, 1, S'(p), 0, "R7");
      for (int i = 0; i < N; i++) cyc(0, 0, '0, 0, "R7");
      idx = -1;
      for (int k = 0; k < N; k++) if (count_o == (N'(1) << k)) idx = k;
      total++;
      if (idx < 0 || carry_o !== (idx < S)) begin
        bad++;
        $display("FAIL R7: pattern %b count=%b carry=%b expected one-hot legal count", S'(p), count_o, carry_o);
      end else begin
        m_cnt = idx; m_known = 1'b1;
        for (int i = 0; i < N; i++) cyc(0, 0, '0, 0, "R7");
      end
    end
    cyc(1, 0, '0, 0, "R3");
    finish_run();
  end
endmodule